// File: doc/BRIEF.md
# Memory Controller Phase Tick Generator

This block divides every reference clock period into four phase points, T1 to T4. Memory-controller outputs can then switch at points inside the period and not only on its rising edge. It runs from a fast sampling clock that ticks 2·N times per reference period, where N is the selected core-to-reference ratio. A slot counter steps through the period, and each phase strobe is one sampling cycle wide. T1 and T3 stay locked to the rising and falling edges of a regenerated reference clock. T2 and T4 are placed from a per-ratio table, so for odd ratios they are not evenly spaced.

The ratio is picked by a 3-bit code that is captured only while reset is held. A second strobe, which fires only at the rising edge, serves logic outside the memory controller that must align to that edge alone. An unsupported code silences every strobe and the regenerated clock, and raises an error flag.

Top module: `tick_phase_gen`

## Requirements
- R1: After reset is released, the first rising sampling edge produces slot 0. At slot 0 of every period `t1` is high for one cycle and `refClk` rises. The period is 2·N slots.
- R2: `t3` is high for one cycle at slot N, the same cycle in which `refClk` falls.
- R3: For ratio codes 1, 2, 4 and 5 (N = 4, 6, 8 and 10, in that order), `t2` fires at slot N/2 and `t4` fires at slot 3N/2.
- R4: For ratio code 0 (N = 3), `t2` fires at slot 1 and `t4` fires at slot 4.
- R5: For ratio code 3 (N = 5), `t2` fires at slot 2 and `t4` fires at slot 7.
- R6: `sysEdge` is high exactly in the cycles in which `t1` is high, and in no other cycle.
- R7: `refClk` is high for slots 0 to N−1 and low for slots N to 2N−1.
- R8: `ratioSel` is sampled only on clock edges while `rstN` is low. A change to it after reset leaves every output unchanged.
- R9: Codes 6 and 7 are unsupported. With either one, `t1` to `t4`, `sysEdge` and `refClk` stay low, and `cfgErr` is high from the first edge after reset. With a supported code, `cfgErr` is low.
- R10: At most one of `t1` to `t4` is high in any cycle, and each of them fires exactly once per period.
- R11: While `rstN` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 2·N ticks per reference period |
| rstN | input | 1 | Active-low reset; the ratio code is captured while it is low |
| ratioSel | input | 3 | Ratio code: 0=3, 1=4, 2=6, 3=5, 4=8, 5=10, 6 and 7 unsupported |
| t1 | output | 1 | Phase strobe at the reference rising edge |
| t2 | output | 1 | Phase strobe at the first inner point |
| t3 | output | 1 | Phase strobe at the reference falling edge |
| t4 | output | 1 | Phase strobe at the second inner point |
| sysEdge | output | 1 | Rising-edge-only strobe for logic outside the memory controller |
| refClk | output | 1 | Regenerated reference clock |
| cfgErr | output | 1 | Unsupported ratio code captured |

## Verification
Two cases are hard to reach from the ports. The first is the odd-ratio placement, where T2 and T4 depart from plain quarter points. The second is proof that a code change made after reset has no effect. The bench resets the block once with each of the eight codes and follows several full periods slot by slot. Midway through each run it drives a different code onto `ratioSel`, so the run shows whether a late change disturbs the captured ratio.

// File: rtl/tick_pkg.sv
package tick_pkg;

  localparam int SEL_W  = 3;
  localparam int SLOT_W = 5;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic  valid;
    slot_t half;
    slot_t inner1;
    slot_t inner3;
    slot_t last;
  } plan_t;

  typedef struct packed {
    logic hitT1;
    logic hitT2;
    logic hitT3;
    logic hitT4;
    logic highHalf;
    logic bad;
  } strobe_t;

  function automatic plan_t makePlan(input int n, input int p2, input int p4);
    plan_t p;
    p.valid  = 1'b1;
    p.half   = slot_t'(n);
    p.inner1 = slot_t'(p2);
    p.inner3 = slot_t'(p4);
    p.last   = slot_t'(2 * n - 1);
    return p;
  endfunction

  function automatic plan_t planFor(input logic [SEL_W-1:0] code);
    plan_t p;
    case (code)
      3'd0:    p = makePlan(3, 1, 4);
      3'd1:    p = makePlan(4, 2, 6);
      3'd2:    p = makePlan(6, 3, 9);
      3'd3:    p = makePlan(5, 2, 7);
      3'd4:    p = makePlan(8, 4, 12);
      3'd5:    p = makePlan(10, 5, 15);
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] ratioSel,
  output strobe_t          hits
);

  logic [SEL_W-1:0] ratioQ;
  plan_t            plan;
  slot_t            slot;

  // Ratio captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) ratioQ <= ratioSel;
  end

  assign plan = planFor(ratioQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 slot <= '0;
    else if (!plan.valid)      slot <= '0;
    else if (slot == plan.last) slot <= '0;
    else                       slot <= slot + slot_t'(1);
  end

  always_comb begin
    hits.hitT1    = plan.valid && (slot == '0);
    hits.hitT2    = plan.valid && (slot == plan.inner1);
    hits.hitT3    = plan.valid && (slot == plan.half);
    hits.hitT4    = plan.valid && (slot == plan.inner3);
    hits.highHalf = plan.valid && (slot < plan.half);
    hits.bad      = !plan.valid;
  end

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (plan.valid && slot == plan.last) |=> (slot == '0)) else $error("slot wrap"); // R10

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    plan.valid |-> (slot <= plan.last)) else $error("slot range"); // R10

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(ratioQ)) else $error("ratio moved"); // R8

endmodule

// File: rtl/tick_out.sv
module tick_out
  import tick_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t hits,
  output logic    t1,
  output logic    t2,
  output logic    t3,
  output logic    t4,
  output logic    sysEdge,
  output logic    refClk,
  output logic    cfgErr
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      t1      <= 1'b0;
      t2      <= 1'b0;
      t3      <= 1'b0;
      t4      <= 1'b0;
      sysEdge <= 1'b0;
      refClk  <= 1'b0;
      cfgErr  <= 1'b0;
    end else begin
      t1      <= hits.hitT1;
      t2      <= hits.hitT2;
      t3      <= hits.hitT3;
      t4      <= hits.hitT4;
      sysEdge <= hits.hitT1;
      refClk  <= hits.highHalf;
      cfgErr  <= hits.bad;
    end
  end

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({t1, t2, t3, t4})) else $error("phase overlap"); // R10

  AST_T1_RISE: assert property (@(posedge clk) disable iff (!rstN)
    t1 |-> (refClk && !$past(refClk))) else $error("t1 off edge"); // R1

  AST_T3_FALL: assert property (@(posedge clk) disable iff (!rstN)
    t3 |-> (!refClk && $past(refClk))) else $error("t3 off edge"); // R2

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !(t1 || t2 || t3 || t4 || refClk || sysEdge)) else $error("err not quiet"); // R9

  AST_SYS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    sysEdge == t1) else $error("sysEdge mismatch"); // R6

endmodule

// File: rtl/tick_phase_gen.sv
module tick_phase_gen
  import tick_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] ratioSel,
  output logic             t1,
  output logic             t2,
  output logic             t3,
  output logic             t4,
  output logic             sysEdge,
  output logic             refClk,
  output logic             cfgErr
);

  strobe_t hits;

  tick_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ratioSel (ratioSel),
    .hits     (hits)
  );

  tick_out u_out (
    .clk     (clk),
    .rstN    (rstN),
    .hits    (hits),
    .t1      (t1),
    .t2      (t2),
    .t3      (t3),
    .t4      (t4),
    .sysEdge (sysEdge),
    .refClk  (refClk),
    .cfgErr  (cfgErr)
  );

endmodule

// File: tb/tick_phase_gen_tb.sv
module tick_phase_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] ratioSel = 3'd0;
  logic t1, t2, t3, t4, sysEdge, refClk, cfgErr;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  tick_phase_gen u_dut (
    .clk(clk), .rstN(rstN), .ratioSel(ratioSel),
    .t1(t1), .t2(t2), .t3(t3), .t4(t4),
    .sysEdge(sysEdge), .refClk(refClk), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratioOf(input int code);
    case (code)
      0: return 3;
      1: return 4;
      2: return 6;
      3: return 5;
      4: return 8;
      5: return 10;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int code = 0; code < 8; code++) begin
      int n;
      int span;
      int c1;
      int c2;
      int c3;
      int c4;
      n = ratioOf(code);
      span = (n > 0) ? 6 * n : 24;
      @(negedge clk);
      rstN = 1'b0;
      ratioSel = 3'(code);
      repeat (3) @(negedge clk);
      check("R11 reset outputs", {t1, t2, t3, t4, sysEdge, refClk, cfgErr}, 0);
      rstN = 1'b1;
      c1 = 0; c2 = 0; c3 = 0; c4 = 0;
      for (int i = 0; i < span; i++) begin
        @(posedge clk);
        @(negedge clk);
        if (i == span / 3) ratioSel = 3'((code + 3) % 8);
        if (n == 0) begin
          check("R9 strobes silent", {t1, t2, t3, t4, sysEdge, refClk}, 0);
          check("R9 cfgErr high", cfgErr, 1);
        end else begin
          int s;
          s = i % (2 * n);
          check("R1 t1 at slot 0", t1, (s == 0) ? 1 : 0);
          check("R2 t3 at slot N", t3, (s == n) ? 1 : 0);
          if (n == 3) begin
            check("R4 t2", t2, (s == 1) ? 1 : 0);
            check("R4 t4", t4, (s == 4) ? 1 : 0);
          end else if (n == 5) begin
            check("R5 t2", t2, (s == 2) ? 1 : 0);
            check("R5 t4", t4, (s == 7) ? 1 : 0);
          end else begin
            check("R3 t2", t2, (s == n / 2) ? 1 : 0);
            check("R3 t4", t4, (s == 3 * n / 2) ? 1 : 0);
          end
          check("R6 sysEdge", sysEdge, (s == 0) ? 1 : 0);
          check("R7 refClk", refClk, (s < n) ? 1 : 0);
          check("R9 cfgErr low", cfgErr, 0);
          check("R10 one phase", int'(t1) + int'(t2) + int'(t3) + int'(t4) <= 1 ? 1 : 0, 1);
          c1 += int'(t1); c2 += int'(t2); c3 += int'(t3); c4 += int'(t4);
          if (i > span / 3)
            check("R8 late select ignored", {t1, t3, refClk},
                  {(s == 0) ? 1'b1 : 1'b0, (s == n) ? 1'b1 : 1'b0, (s < n) ? 1'b1 : 1'b0});
        end
      end
      if (n > 0) begin
        check("R10 t1 once per period", c1, 3);
        check("R10 t2 once per period", c2, 3);
        check("R10 t3 once per period", c3, 3);
        check("R10 t4 once per period", c4, 3);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule